// File: doc/BRIEF.md
# Hazard-Searchable Instruction Queue

This block is the queue between the fetch/decode stage and the execute stage of a small two-stage in-order processor. Decode pushes decoded instruction templates into it. Execute reads the oldest template and pops it. A taken branch in execute flushes the whole queue.

Decode also needs to know whether an instruction still in flight will write a register it is about to read. For that, the queue has a combinational lookup port. It takes a 5-bit register name and answers in the same cycle whether any live entry targets that register.

Within one cycle the operations act in a fixed order:
1. Execute's read and pop act first.
2. The lookup and the push follow.
3. The flush overrides everything.

Because the pop acts first, a full queue still accepts a push in a cycle where the head leaves. A lookup never reports the entry that is leaving in that cycle.

Top module: `hzq_fifo`

## Requirements
- R1: `enq_ready` is high when fewer than DEPTH entries are held, or when `deq_req` is high while the queue is non-empty. A push is accepted when `enq_valid` and `enq_ready` are both high and `flush` is low.
- R2: `head_valid` is high exactly when the queue holds an entry. While it is high, `head_kind`, `head_dest`, `head_a` and `head_b` show the oldest accepted entry, and entries leave in the order they were accepted.
- R3: A push offered while the queue holds DEPTH entries and no pop occurs is not accepted. The queue contents are unchanged.
- R4: A pop requested while the queue is empty has no effect. While empty, the head fields keep the last values they showed while `head_valid` was high, or zero if nothing was ever held.
- R5: `probe_hit` is high when some held entry has kind add (code 0) or load (code 2) and its destination field equals `probe_reg`.
- R6: Entries of kind branch-if-zero (code 1) and store (code 3) never make `probe_hit` high, whatever their destination field holds.
- R7: In a cycle where `deq_req` is high on a non-empty queue, the head entry is left out of the lookup. An entry offered for push in the current cycle is never seen by the lookup in that same cycle.
- R8: `flush` empties the queue at the next clock edge. A push in the same cycle is discarded.
- R9: After reset the queue is empty, `enq_ready` is high and `probe_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Decode offers a template |
| enq_kind | input | 2 | Template kind: 0 add, 1 branch-if-zero, 2 load, 3 store |
| enq_dest | input | 5 | Destination register of the template |
| enq_a | input | 32 | First value field |
| enq_b | input | 32 | Second value field |
| enq_ready | output | 1 | Queue can take the offered template this cycle |
| deq_req | input | 1 | Execute pops the head |
| head_valid | output | 1 | Head fields hold a live entry |
| head_kind | output | 2 | Kind of oldest entry |
| head_dest | output | 5 | Destination of oldest entry |
| head_a | output | 32 | First value of oldest entry |
| head_b | output | 32 | Second value of oldest entry |
| flush | input | 1 | Empty the queue; overrides a push |
| probe_reg | input | 5 | Register name to look up |
| probe_hit | output | 1 | Some live add/load entry writes `probe_reg` |

## Verification
The bench targets four corner cases:
- **Push and pop in the same cycle on a full queue, repeated back to back.** A design that decides readiness from occupancy alone would stall here and halve throughput.
- **A lookup whose only matching entry is the head being popped.** A design that searches before the pop would report a false hazard and stall decode for no reason.
- **A flush racing a push.** A design that lets the push through would leave a wrong-path template behind the branch.
- **A pop on an empty queue, and branch or store entries whose destination field equals the probe.** A wrong design would corrupt the pointers in the first case and raise false hazards in the second.

// File: rtl/hzq_pkg.sv
package hzq_pkg;

    localparam int REG_W = 5;
    localparam int VAL_W = 32;

    typedef enum logic [1:0] {
        K_ADD   = 2'd0,
        K_BRZ   = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [REG_W-1:0]   dest;
        logic [VAL_W-1:0]   a;
        logic [VAL_W-1:0]   b;
    } tmpl_t;

endpackage

// File: rtl/hzq_ctrl.sv
module hzq_ctrl #(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             deq_req,
    input  logic             flush,
    output logic             enq_ready,
    output logic             do_enq,
    output logic             head_live,
    output logic             mask_head,
    output logic [PW-1:0]    wr_ptr,
    output logic [PW-1:0]    rd_ptr,
    output logic [CW-1:0]    cnt,
    output logic [DEPTH-1:0] vld
);

    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic [CW-1:0]    cnt;
        logic [DEPTH-1:0] vld;
    } st_t;

    st_t st_d, st_q;
    logic empty, full, do_deq;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        empty     = (st_q.cnt == '0);
        full      = (st_q.cnt == CW'(DEPTH));
        mask_head = deq_req && !empty;
        do_deq    = mask_head && !flush;
        enq_ready = !full || mask_head;
        do_enq    = enq_valid && enq_ready && !flush;

        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_deq) begin
                st_d.vld[st_q.rd] = 1'b0;
                st_d.rd           = bump(st_q.rd);
            end
            if (do_enq) begin
                st_d.vld[st_q.wr] = 1'b1;
                st_d.wr           = bump(st_q.wr);
            end
            st_d.cnt = st_q.cnt + CW'(do_enq) - CW'(do_deq);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_live = !empty;
    assign wr_ptr    = st_q.wr;
    assign rd_ptr    = st_q.rd;
    assign cnt       = st_q.cnt;
    assign vld       = st_q.vld;

endmodule

// File: rtl/hzq_slots.sv
module hzq_slots
    import hzq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [PW-1:0]                waddr,
    input  tmpl_t                        wdata,
    input  logic [PW-1:0]                raddr,
    input  logic                         live,
    output tmpl_t                        head_o,
    output kind_e [DEPTH-1:0]            kind_o,
    output logic  [DEPTH-1:0][REG_W-1:0] dest_o
);

    tmpl_t [DEPTH-1:0] mem_d, mem_q;
    tmpl_t             last_d, last_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
        last_d = live ? mem_q[raddr] : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q  <= '0;
            last_q <= '0;
        end else begin
            mem_q  <= mem_d;
            last_q <= last_d;
        end
    end

    assign head_o = live ? mem_q[raddr] : last_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tag
        assign kind_o[i] = mem_q[i].kind;
        assign dest_o[i] = mem_q[i].dest;
    end

endmodule

// File: rtl/hzq_search.sv
module hzq_search
    import hzq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  kind_e [DEPTH-1:0]            kind_i,
    input  logic  [DEPTH-1:0][REG_W-1:0] dest_i,
    input  logic  [DEPTH-1:0]            vld_i,
    input  logic                         mask_en,
    input  logic  [PW-1:0]               mask_idx,
    input  logic  [REG_W-1:0]            key,
    output logic                         hit
);

    logic [DEPTH-1:0] match_w;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic writes_reg, leaving;
        assign writes_reg = (kind_i[i] == K_ADD) || (kind_i[i] == K_LOAD);
        assign leaving    = mask_en && (mask_idx == PW'(i));
        assign match_w[i] = vld_i[i] && !leaving && writes_reg && (dest_i[i] == key);
    end

    assign hit = |match_w;

endmodule

// File: rtl/hzq_fifo.sv
module hzq_fifo
    import hzq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [1:0]       enq_kind,
    input  logic [REG_W-1:0] enq_dest,
    input  logic [VAL_W-1:0] enq_a,
    input  logic [VAL_W-1:0] enq_b,
    output logic             enq_ready,
    input  logic             deq_req,
    output logic             head_valid,
    output logic [1:0]       head_kind,
    output logic [REG_W-1:0] head_dest,
    output logic [VAL_W-1:0] head_a,
    output logic [VAL_W-1:0] head_b,
    input  logic             flush,
    input  logic [REG_W-1:0] probe_reg,
    output logic             probe_hit
);

    logic                         do_enq_w, mask_w;
    logic [PW-1:0]                wr_w, rd_w;
    logic [CW-1:0]                cnt_w;
    logic [DEPTH-1:0]             vld_w;
    tmpl_t                        in_w, head_w;
    kind_e [DEPTH-1:0]            kinds_w;
    logic  [DEPTH-1:0][REG_W-1:0] dests_w;

    assign in_w = '{kind: kind_e'(enq_kind), dest: enq_dest, a: enq_a, b: enq_b};

    hzq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .deq_req   (deq_req),
        .flush     (flush),
        .enq_ready (enq_ready),
        .do_enq    (do_enq_w),
        .head_live (head_valid),
        .mask_head (mask_w),
        .wr_ptr    (wr_w),
        .rd_ptr    (rd_w),
        .cnt       (cnt_w),
        .vld       (vld_w)
    );

    hzq_slots #(.DEPTH(DEPTH)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (do_enq_w),
        .waddr  (wr_w),
        .wdata  (in_w),
        .raddr  (rd_w),
        .live   (head_valid),
        .head_o (head_w),
        .kind_o (kinds_w),
        .dest_o (dests_w)
    );

    hzq_search #(.DEPTH(DEPTH)) u_search (
        .kind_i   (kinds_w),
        .dest_i   (dests_w),
        .vld_i    (vld_w),
        .mask_en  (mask_w),
        .mask_idx (rd_w),
        .key      (probe_reg),
        .hit      (probe_hit)
    );

    assign head_kind = head_w.kind;
    assign head_dest = head_w.dest;
    assign head_a    = head_w.a;
    assign head_b    = head_w.b;

endmodule

// File: rtl/hzq_fifo_chk.sv
module hzq_fifo_chk #(
    parameter int DEPTH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             deq_req,
    input logic             flush,
    input logic             enq_ready,
    input logic             head_valid,
    input logic [31:0]      head_a,
    input logic             probe_hit,
    input logic [CW-1:0]    cnt,
    input logic [DEPTH-1:0] vld
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && !deq_req) |-> !enq_ready);

    p_valid_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld) == int'(cnt));

    p_hit_needs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        probe_hit |-> head_valid);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);

    p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && $past(!head_valid)) |-> $stable(head_a));

endmodule

bind hzq_fifo hzq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .deq_req    (deq_req),
    .flush      (flush),
    .enq_ready  (enq_ready),
    .head_valid (head_valid),
    .head_a     (head_a),
    .probe_hit  (probe_hit),
    .cnt        (cnt_w),
    .vld        (vld_w)
);

// File: tb/tb_hzq_fifo.sv
module tb_hzq_fifo;
    import hzq_pkg::*;

    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [1:0]  enq_kind = '0;
    logic [4:0]  enq_dest = '0;
    logic [31:0] enq_a = '0, enq_b = '0;
    logic        enq_ready;
    logic        deq_req = 1'b0;
    logic        head_valid;
    logic [1:0]  head_kind;
    logic [4:0]  head_dest;
    logic [31:0] head_a, head_b;
    logic        flush = 1'b0;
    logic [4:0]  probe_reg = '0;
    logic        probe_hit;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    tmpl_t exp_q[$];
    tmpl_t last_shown = '0;

    always #4 clk = ~clk;

    hzq_fifo #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic tmpl_t mk(input kind_e k, input logic [4:0] d, input logic [31:0] a, input logic [31:0] b);
        return '{kind: k, dest: d, a: a, b: b};
    endfunction

    // Monitor: compare the head against the scoreboard front (R2, R4)
    task automatic monitor_head();
        tmpl_t got;
        got = '{kind: kind_e'(head_kind), dest: head_dest, a: head_a, b: head_b};
        if (exp_q.size() > 0) begin
            chk(head_valid === 1'b1, "R2 head_valid", head_valid, 1);
            chk(got === exp_q[0], "R2 head order", got, exp_q[0]);
            last_shown = exp_q[0];
        end else begin
            chk(head_valid === 1'b0, "R4 head_valid empty", head_valid, 0);
            chk(got === last_shown, "R4 head held", got, last_shown);
        end
    endtask

    // Driver: one cycle of stimulus, checks, then scoreboard update
    task automatic step(input bit ev, input tmpl_t e, input bit dq, input bit fl, input logic [4:0] key);
        bit exp_ready, exp_hit, popping;
        int first;
        @(negedge clk);
        enq_valid = ev; enq_kind = e.kind; enq_dest = e.dest; enq_a = e.a; enq_b = e.b;
        deq_req = dq; flush = fl; probe_reg = key;
        #2;
        popping   = dq && (exp_q.size() > 0);
        exp_ready = (exp_q.size() < DEPTH) || popping;
        chk(enq_ready === exp_ready, "R1 enq_ready", enq_ready, exp_ready);
        first   = popping ? 1 : 0;
        exp_hit = 0;
        for (int i = first; i < exp_q.size(); i++)
            if ((exp_q[i].kind == K_ADD || exp_q[i].kind == K_LOAD) && exp_q[i].dest == key)
                exp_hit = 1;
        chk(probe_hit === exp_hit, "R5/R6/R7 probe_hit", probe_hit, exp_hit);
        monitor_head();
        if (popping) void'(exp_q.pop_front());
        if (fl) exp_q.delete();
        else if (ev && exp_ready) exp_q.push_back(e);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        tmpl_t z;
        z = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9: reset state
        chk(head_valid === 1'b0, "R9 head_valid", head_valid, 0);
        chk(enq_ready === 1'b1, "R9 enq_ready", enq_ready, 1);
        chk(probe_hit === 1'b0, "R9 probe_hit", probe_hit, 0);

        // R7: same-cycle push is not visible to the lookup
        step(1, mk(K_ADD, 5'd3, 32'd10, 32'd20), 0, 0, 5'd3);
        step(1, mk(K_LOAD, 5'd7, 32'd30, 32'd0), 0, 0, 5'd3);
        // R3: full with no pop rejects the push
        step(1, mk(K_STORE, 5'd3, 32'd1, 32'd2), 0, 0, 5'd7);
        chk(exp_q.size() == 2, "R3 queue unchanged", exp_q.size(), 2);
        // R7: only matching entry is the head being popped; full push+pop (R1)
        step(1, mk(K_BRZ, 5'd3, 32'd0, 32'd40), 1, 0, 5'd3);
        // R6: branch with dest 3 does not match
        step(0, z, 0, 0, 5'd3);
        step(1, mk(K_STORE, 5'd7, 32'd5, 32'd6), 1, 0, 5'd7);
        step(0, z, 0, 0, 5'd7);
        // R8: flush racing a push
        step(1, mk(K_ADD, 5'd9, 32'd1, 32'd1), 0, 1, 5'd9);
        step(0, z, 0, 0, 5'd9);
        chk(head_valid === 1'b0, "R8 flushed empty", head_valid, 0);
        // R4: pop on empty queue ignored
        step(0, z, 1, 0, 5'd0);
        step(0, z, 1, 0, 5'd0);
        step(1, mk(K_LOAD, 5'd12, 32'hAA, 32'hBB), 0, 0, 5'd12);
        step(0, z, 0, 0, 5'd12);

        // back-to-back push and pop at full occupancy
        step(1, mk(K_ADD, 5'd13, 32'h11, 32'h22), 0, 0, 5'd13);
        for (int i = 0; i < 24; i++) begin
            kind_e k;
            k = kind_e'(i % 4);
            step(1, mk(k, 5'(i % 6), 32'(i * 7), 32'(i + 100)), 1, 0, 5'(i % 6));
        end
        step(0, z, 1, 0, 5'd2);
        step(0, z, 1, 0, 5'd3);
        step(0, z, 0, 0, 5'd3);

        // flush together with a pop on a full queue
        step(1, mk(K_ADD, 5'd1, 32'd1, 32'd1), 0, 0, 5'd1);
        step(1, mk(K_LOAD, 5'd2, 32'd2, 32'd2), 0, 0, 5'd1);
        step(1, mk(K_ADD, 5'd4, 32'd4, 32'd4), 1, 1, 5'd2);
        step(0, z, 0, 0, 5'd2);
        step(0, z, 0, 0, 5'd4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule